// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single 32-bit timer channel reached through a small register port. Software loads a start count into the live counter, chooses one of two tick sources (the core clock, or an external slow-oscillator pulse that is synchronous to the core clock), and sets a power-of-two prescale exponent. When enabled, the counter steps down by one on every prescaled tick. When it steps from 1 to 0 the timer latches a pending flag. That flag drives the interrupt line whenever the interrupt enable bit is set.

Auto-reload mode makes the timer periodic: on the expiring tick the counter takes the interval register value and keeps running. One-shot mode leaves the counter at zero and has the hardware drop the enable bit. The live counter can be written at any time, so the first expiry can differ from the steady period. A common sequence is to arm a one-shot with one delay, then, on its interrupt, load a new count and switch to periodic operation.

The register port is a plain single-cycle write strobe with a combinational read. It has no handshake and no data stream, so no valid/ready back-pressure applies.

Top module: `interval_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The register map is fixed. 0x00 is interrupt enable (bit 0). 0x04 is pending status (bit 0). 0x10 is control: bit 0 enable, bit 1 auto-reload, bit 2 tick source, bits [6:4] prescale exponent. 0x14 is the interval value. 0x18 is the current count. Any other address reads zero.
- R3: The counter changes only on a prescaled tick while enable is set, or on a direct write. With enable clear it holds its value.
- R4: With prescale exponent k, one count step takes 2^k source ticks. A count of N therefore expires N·2^k source ticks after enable.
- R5: Control bit 2 = 0 takes every core clock cycle as a source tick. Bit 2 = 1 takes only cycles with `osc_tick` high.
- R6: Expiry is the 1-to-0 step of the counter. It sets status bit 0. A counter already at zero neither counts nor expires.
- R7: On a one-shot expiry (auto-reload clear), hardware clears control bit 0 and the counter stays at zero.
- R8: On a periodic expiry (auto-reload set), the counter takes the interval value on that same tick and keeps counting with enable still set.
- R9: A write to 0x18 loads the counter directly and takes priority over a tick in the same cycle.
- R10: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as the clear wins.
- R11: `irq` is high exactly while status bit 0 and interrupt-enable bit 0 are both set. It is a level that stays high until cleared.
- R12: Reading 0x18 returns the live counter value in the cycle it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse from the slow oscillator, synchronous to clk |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
Several properties are checked on every cycle. The counter holds when no tick and no load arrive. Ticks appear only while enabled and only from the selected source. Every expiry sets the pending flag. The flag stays set until a clear write. A one-shot expiry leaves the counter at zero with enable dropped, and a periodic expiry loads the interval. Other behaviours need the bench's scenarios. These are the exact expiry cycle under each prescale exponent, counting of oscillator pulses, priority of a direct load over a tick, the sequence of counter values across a reload, and the race between a clear and an expiry in the same cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_IE   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STS  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_IVAL = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_CUR  = 8'h18;
  localparam int CTRL_EN    = 0;
  localparam int CTRL_RELD  = 1;
  localparam int CTRL_SRC   = 2;
  localparam int CTRL_EXP_LO = 4;
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int PRE_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                src_osc,
  input  logic                osc_tick,
  input  logic [PRE_BITS-1:0] exp_sel,
  output logic                tick
);
  localparam int PW = (1 << PRE_BITS) - 1;

  logic [PW-1:0] pcnt;
  logic [PW:0]   span;
  logic [PW-1:0] mask;
  logic          base;

  always_comb begin
    base = src_osc ? osc_tick : 1'b1;
    span = (PW+1)'(1) << exp_sel;
    mask = PW'(span - (PW+1)'(1));
    tick = en && base && ((pcnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) pcnt <= '0;
    else if (base)     pcnt <= tick ? '0 : pcnt + PW'(1);
  end

  // R3: no tick while the channel is disabled
  assert_tick_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);
  // R5: oscillator source ticks only on oscillator pulses
  assert_tick_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_osc && !osc_tick) |-> !tick);
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reload,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] interval,
  output logic [W-1:0] cnt,
  output logic         expire
);
  assign expire = tick && !ld && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (ld)                  cnt <= ld_val;
    else if (tick && cnt != '0) begin
      if (cnt == W'(1))           cnt <= reload ? interval : '0;
      else                        cnt <= cnt - W'(1);
    end
  end

  // R3: without a tick or a load the counter holds
  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !tick) |=> $stable(cnt));
  // R7: one-shot expiry parks the counter at zero
  assert_oneshot_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload) |=> (cnt == '0));
  // R8: periodic expiry loads the interval
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload) |=> (cnt == $past(interval)));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  input  logic ie_wr,
  input  logic ie_val,
  output logic sts,
  output logic ie,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= 1'b0;
      ie  <= 1'b0;
    end else begin
      if (expire)   sts <= 1'b1;
      else if (clr) sts <= 1'b0;
      if (ie_wr)    ie  <= ie_val;
    end
  end

  assign irq = sts & ie;

  // R6: every expiry leaves the pending flag set
  assert_set_on_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> sts);
  // R10: pending flag only falls through a clear write
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr) |=> sts);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int W        = 32,
  parameter int PRE_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq
);
  logic                en_q, reld_q, src_q;
  logic [PRE_BITS-1:0] exp_q;
  logic [W-1:0]        ival_q;
  logic [W-1:0]        cnt;
  logic                tick, expire, sts, ie;
  logic                wr_ie, wr_sts, wr_ctrl, wr_ival, wr_cur;

  always_comb begin
    wr_ie   = bus_wr && bus_addr == OFF_IE;
    wr_sts  = bus_wr && bus_addr == OFF_STS;
    wr_ctrl = bus_wr && bus_addr == OFF_CTRL;
    wr_ival = bus_wr && bus_addr == OFF_IVAL;
    wr_cur  = bus_wr && bus_addr == OFF_CUR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      reld_q <= 1'b0;
      src_q  <= 1'b0;
      exp_q  <= '0;
      ival_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= bus_wdata[CTRL_EN];
        reld_q <= bus_wdata[CTRL_RELD];
        src_q  <= bus_wdata[CTRL_SRC];
        exp_q  <= bus_wdata[CTRL_EXP_LO +: PRE_BITS];
      end else if (expire && !reld_q) begin
        en_q   <= 1'b0;
      end
      if (wr_ival) ival_q <= bus_wdata;
    end
  end

  tick_gen #(.PRE_BITS(PRE_BITS)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en_q), .src_osc(src_q),
    .osc_tick(osc_tick), .exp_sel(exp_q), .tick(tick));

  count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reld_q),
    .ld(wr_cur), .ld_val(bus_wdata), .interval(ival_q),
    .cnt(cnt), .expire(expire));

  irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire),
    .clr(wr_sts && bus_wdata[0]), .ie_wr(wr_ie), .ie_val(bus_wdata[0]),
    .sts(sts), .ie(ie), .irq(irq));

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_IE:   bus_rdata[0] = ie;
      OFF_STS:  bus_rdata[0] = sts;
      OFF_CTRL: begin
        bus_rdata[CTRL_EN]   = en_q;
        bus_rdata[CTRL_RELD] = reld_q;
        bus_rdata[CTRL_SRC]  = src_q;
        bus_rdata[CTRL_EXP_LO +: PRE_BITS] = exp_q;
      end
      OFF_IVAL: bus_rdata = ival_q;
      OFF_CUR:  bus_rdata = cnt;
      default:  bus_rdata = '0;
    endcase
  end

  // R7: one-shot expiry drops the enable bit unless software rewrites control
  assert_oneshot_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reld_q && !wr_ctrl) |=> !en_q);
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        osc_tick = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  interval_timer u_interval_timer (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % 3;
      osc_tick = (c == 0);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk);
    #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_expiry(input int limit, output int n);
    logic [31:0] v;
    n = 0;
    bus_addr = 8'h04;
    while (n < limit) begin
      @(posedge clk); n++;
      #1 rd(8'h04, v);
      if (v[0]) return;
    end
  endtask

  task automatic clear_all();
    wr(8'h10, 0); wr(8'h04, 1); wr(8'h00, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    foreach (v[i]) v[i] = 1'b1;
    rd(8'h00, v); check(v == 0, "R1 ie", v, 0);
    rd(8'h04, v); check(v == 0, "R1 sts", v, 0);
    rd(8'h10, v); check(v == 0, "R1 ctrl", v, 0);
    rd(8'h14, v); check(v == 0, "R1 ival", v, 0);
    rd(8'h18, v); check(v == 0, "R1 cur", v, 0);
    check(irq == 0, "R1 irq", irq, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(8'h14, 32'hA5A5_0001);
    rd(8'h14, v); check(v == 32'hA5A5_0001, "R2 ival readback", v, 32'hA5A5_0001);
    wr(8'h10, 32'h0000_0064);
    rd(8'h10, v); check(v == 32'h64, "R2 ctrl fields", v, 32'h64);
    rd(8'h08, v); check(v == 0, "R2 unmapped", v, 0);
    wr(8'h10, 0);
  endtask

  task automatic t_hold_disabled();
    logic [31:0] v;
    wr(8'h18, 7);
    repeat (10) @(posedge clk);
    #1 rd(8'h18, v); check(v == 7, "R3 hold when disabled", v, 7);
  endtask

  task automatic t_oneshot();
    logic [31:0] v; int n;
    wr(8'h18, 5);
    wr(8'h10, 32'h1);
    @(posedge clk); #1 rd(8'h18, v);
    check(v == 4, "R12 live count", v, 4);
    wait_expiry(50, n);
    check(n == 4, "R6 one-shot expiry cycle", n, 4);
    rd(8'h10, v); check(v[0] == 0, "R7 enable cleared", v[0], 0);
    repeat (5) @(posedge clk);
    #1 rd(8'h18, v); check(v == 0, "R7 count stays zero", v, 0);
    check(irq == 0, "R11 irq masked", irq, 0);
    wr(8'h00, 1);
    #1 check(irq == 1, "R11 irq raised", irq, 1);
    wr(8'h04, 0);
    rd(8'h04, v); check(v[0] == 1, "R10 write 0 keeps", v[0], 1);
    #1 check(irq == 1, "R11 irq level held", irq, 1);
    wr(8'h04, 1);
    rd(8'h04, v); check(v[0] == 0, "R10 write 1 clears", v[0], 0);
    #1 check(irq == 0, "R11 irq drops", irq, 0);
    clear_all();
  endtask

  task automatic t_prescale();
    int n;
    wr(8'h18, 3);
    wr(8'h10, 32'h21);
    wait_expiry(100, n);
    check(n == 12, "R4 prescale 2^2 expiry", n, 12);
    clear_all();
    wr(8'h18, 2);
    wr(8'h10, 32'h31);
    wait_expiry(100, n);
    check(n == 16, "R4 prescale 2^3 expiry", n, 16);
    clear_all();
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    logic [31:0] expv [6] = '{1, 4, 3, 2, 1, 4};
    wr(8'h14, 4);
    wr(8'h18, 2);
    wr(8'h10, 32'h3);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1 rd(8'h18, v);
      check(v == expv[i], "R8 periodic sequence", v, expv[i]);
      if (i == 1) begin
        rd(8'h04, v); check(v[0] == 1, "R6 periodic sets pending", v[0], 1);
        rd(8'h10, v); check(v[0] == 1, "R8 enable kept", v[0], 1);
      end
    end
    wr(8'h18, 9);
    rd(8'h18, v); check(v == 9, "R9 load beats tick", v, 9);
    clear_all();
  endtask

  task automatic t_osc();
    logic [31:0] v; int pulses; bit hit;
    wr(8'h18, 2);
    wr(8'h10, 32'h5);
    pulses = 0; hit = 0;
    for (int i = 0; i < 20 && !hit; i++) begin
      @(posedge clk);
      if (osc_tick) pulses++;
      #1 rd(8'h04, v);
      if (v[0]) hit = 1;
    end
    check(hit && pulses == 2, "R5 oscillator pulses counted", pulses, 2);
    clear_all();
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(8'h18, 2);
    wr(8'h10, 32'h1);
    @(posedge clk);
    wr(8'h04, 1);
    rd(8'h04, v); check(v[0] == 1, "R10 expiry beats clear", v[0], 1);
    clear_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_map();
    t_hold_disabled();
    t_oneshot();
    t_prescale();
    t_periodic();
    t_osc();
    t_race();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule